// File: doc/BRIEF.md
# Floating-Point Status Register Move Unit

This unit carries out the instructions that read and modify the floating-point status and control register. It holds that 32-bit register together with the 32-bit condition register. Each cycle it may accept one decoded operation along with the raw 32-bit instruction word and a 64-bit floating-point register operand. In the next cycle it presents the updated registers. It can act in six ways:

- force a single status bit to one;
- force a single status bit to zero;
- load a 4-bit immediate into one status field;
- load any chosen subset of the eight status fields from a register operand, selected by an 8-bit mask;
- copy one status field into a condition-register field and clear that field's sticky exception flags;
- return the whole status register as a 64-bit register result.

Fields and bits use big-endian numbering. Field 0 is status bits [31:28], field 7 is bits [3:0], and status bit number n is register bit 31-n. The unit checks the reserved bits of each instruction form. A malformed instruction changes nothing and raises a one-cycle illegal flag.

Top module: `fpstat_move_unit`

## Requirements
- R1: During and after reset, `status_q`, `cr_q` and `fpr_res` are zero, and `fpr_we` and `illegal` are low.
- R2: Operation code 1 sets and code 2 clears status bit number n, where n is `instr[25:21]` and the bit is register bit 31-n. Either operation is illegal if any of `instr[20:11]` is nonzero.
- R3: Operation code 4 copies the corresponding nibble of `fpr_src[31:0]` into every field i whose enable bit `instr[24-i]` is set. Fields whose enable bit is clear keep their value, and `fpr_src[63:32]` has no effect.
- R4: Operation code 4 is illegal when `instr[25]` or `instr[16]` is set.
- R5: Operation code 3 writes `instr[15:12]` into the field numbered `instr[26:23]`. It is illegal when that number exceeds 7, or when any of `instr[22:16]` or `instr[11]` is set.
- R6: Operation code 5 copies status field `instr[20:18]` into condition field `instr[25:23]`, which is register bits [31-4k:28-4k]. It then clears the sticky flags of the source field, given as nibble masks with the leftmost bit first: field 0 clears 1001, fields 1 and 2 clear 1111, field 5 clears 0111, and every other field clears nothing.
- R7: Operation code 5 is illegal when any of `instr[15:11]`, `instr[22:21]` or `instr[17:16]` is nonzero.
- R8: Operation code 6 places `{32'h0, status_q}` on `fpr_res` and pulses `fpr_we` for one cycle. It is illegal if any of `instr[20:11]` is nonzero.
- R9: When `instr[0]` is set on a legal operation other than code 5, condition bits [27:25] are cleared and bit 24 is kept. Code 5 ignores `instr[0]`.
- R10: An illegal operation, or operation code 0 or 7, leaves both registers unchanged and raises `illegal` for exactly one cycle. A cycle with `op_valid` low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | Decoded operation (1 set, 2 clear, 3 immediate, 4 masked, 5 copy, 6 read) |
| instr | input | 32 | Raw instruction word |
| fpr_src | input | 64 | Floating-point register operand for masked writes |
| status_q | output | 32 | Status and control register |
| cr_q | output | 32 | Condition register |
| fpr_res | output | 64 | Register result of the read operation |
| fpr_we | output | 1 | One-cycle strobe for `fpr_res` |
| illegal | output | 1 | One-cycle illegal-form flag |

## Verification
The bit operations are tried at both ends of the index range, which catches a reversed bit order. Masked writes use a sparse mask on the two end fields, an all-ones mask, and an empty mask. This separates field order from mask order and shows that the upper operand half is ignored. Copies read fields 0, 1, 2, 3 and 5 with differing sticky masks, so a wrong clear table or a swapped source and destination gives a distinct value. Every reserved bit class of each form is set once, and each such case must leave both registers unchanged.

// File: rtl/fpstat_move_unit.sv
module fpstat_move_unit #(
  parameter int NFIELD = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [2:0]  op_code,
  input  logic [31:0] instr,
  input  logic [63:0] fpr_src,
  output logic [31:0] status_q,
  output logic [31:0] cr_q,
  output logic [63:0] fpr_res,
  output logic        fpr_we,
  output logic        illegal
);
  localparam logic [2:0] OP_SET  = 3'd1;
  localparam logic [2:0] OP_CLR  = 3'd2;
  localparam logic [2:0] OP_IMM  = 3'd3;
  localparam logic [2:0] OP_MSK  = 3'd4;
  localparam logic [2:0] OP_COPY = 3'd5;
  localparam logic [2:0] OP_READ = 3'd6;

  function automatic logic [3:0] sticky_of(input logic [2:0] f);
    case (f)
      3'd0:      sticky_of = 4'b1001;
      3'd1, 3'd2: sticky_of = 4'b1111;
      3'd5:      sticky_of = 4'b0111;
      default:   sticky_of = 4'b0000;
    endcase
  endfunction

  logic [31:0] st_n, cr_n;
  logic        bad, rd_op;
  logic [2:0]  cp_dst, cp_src;
  logic [3:0]  cp_nib;

  assign cp_dst = instr[25:23];
  assign cp_src = instr[20:18];
  assign cp_nib = status_q[{~cp_src, 2'b11} -: 4];

  always_comb begin
    st_n  = status_q;
    cr_n  = cr_q;
    bad   = 1'b0;
    rd_op = 1'b0;
    case (op_code)
      OP_SET: begin
        bad = |instr[20:11];
        st_n[5'd31 - instr[25:21]] = 1'b1;
      end
      OP_CLR: begin
        bad = |instr[20:11];
        st_n[5'd31 - instr[25:21]] = 1'b0;
      end
      OP_IMM: begin
        bad = instr[26] | (|instr[22:16]) | instr[11];
        st_n[{~instr[25:23], 2'b11} -: 4] = instr[15:12];
      end
      OP_MSK: begin
        bad = instr[25] | instr[16];
        for (int i = 0; i < NFIELD; i++)
          if (instr[24-i]) st_n[31-4*i -: 4] = fpr_src[31-4*i -: 4];
      end
      OP_COPY: begin
        bad = (|instr[15:11]) | (|instr[22:21]) | (|instr[17:16]);
        cr_n[{~cp_dst, 2'b11} -: 4] = cp_nib;
        st_n[{~cp_src, 2'b11} -: 4] = cp_nib & ~sticky_of(cp_src);
      end
      OP_READ: begin
        bad   = |instr[20:11];
        rd_op = 1'b1;
      end
      default: bad = 1'b1;
    endcase
    if (instr[0] && op_code != OP_COPY) cr_n[27:25] = 3'b000;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      cr_q     <= '0;
      fpr_res  <= '0;
      fpr_we   <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      illegal <= op_valid & bad;
      fpr_we  <= op_valid & ~bad & rd_op;
      if (op_valid && !bad) begin
        status_q <= st_n;
        cr_q     <= cr_n;
        if (rd_op) fpr_res <= {32'h0, status_q};
      end
    end
  end
endmodule

module fpstat_move_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [2:0]  op_code,
  input logic [31:0] instr,
  input logic [31:0] status_q,
  input logic [31:0] cr_q,
  input logic [63:0] fpr_res,
  input logic        fpr_we,
  input logic        illegal
);
  assert_set_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(op_valid) && $past(op_code) == 3'd1 && !illegal)
      |-> status_q[5'd31 - $past(instr[25:21])] == 1'b1);

  assert_read_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fpr_we |-> fpr_res == {32'h0, $past(status_q)});

  assert_record_cr1_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(op_valid) && $past(instr[0]) && $past(op_code) != 3'd5 && !illegal)
      |-> (cr_q[27:25] == 3'b000 && cr_q[24] == $past(cr_q[24])));

  assert_illegal_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> ($stable(status_q) && $stable(cr_q) && !fpr_we));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(op_valid) |-> ($stable(status_q) && $stable(cr_q) && !illegal && !fpr_we));
endmodule

bind fpstat_move_unit fpstat_move_unit_chk chk_i (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .instr(instr), .status_q(status_q), .cr_q(cr_q), .fpr_res(fpr_res),
  .fpr_we(fpr_we), .illegal(illegal)
);

// File: tb/fpstat_move_unit_tb.sv
module fpstat_move_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = 3'd0;
  logic [31:0] instr = 32'h0;
  logic [63:0] fpr_src = 64'h0;
  logic [31:0] status_q, cr_q;
  logic [63:0] fpr_res;
  logic        fpr_we, illegal;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fpstat_move_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .instr(instr), .fpr_src(fpr_src), .status_q(status_q), .cr_q(cr_q),
    .fpr_res(fpr_res), .fpr_we(fpr_we), .illegal(illegal)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] ins;
    logic [63:0] src;
    logic [31:0] st;
    logic [31:0] cr;
    logic        ill;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 32'h0000_0000, 64'h0, 32'h8000_0000, 32'h0000_0000, 1'b0, 4'd2},  // R2 n=0
    '{3'd1, 32'h03E0_0000, 64'h0, 32'h8000_0001, 32'h0000_0000, 1'b0, 4'd2},  // R2 n=31
    '{3'd2, 32'h0000_0000, 64'h0, 32'h0000_0001, 32'h0000_0000, 1'b0, 4'd2},  // R2 clear
    '{3'd3, 32'h0100_A000, 64'h0, 32'h00A0_0001, 32'h0000_0000, 1'b0, 4'd5},  // R5 field 2
    '{3'd3, 32'h0100_A800, 64'h0, 32'h00A0_0001, 32'h0000_0000, 1'b1, 4'd5},  // R5 bit 11
    '{3'd3, 32'h0480_A000, 64'h0, 32'h00A0_0001, 32'h0000_0000, 1'b1, 4'd5},  // R5 field 9
    '{3'd4, 32'h0102_0000, 64'hFFFF_FFFF_1234_5678, 32'h10A0_0008, 32'h0, 1'b0, 4'd3}, // R3 ends
    '{3'd4, 32'h0103_0000, 64'h0, 32'h10A0_0008, 32'h0000_0000, 1'b1, 4'd4},  // R4 bit 16
    '{3'd4, 32'h01FE_0000, 64'h0000_0000_F7F7_FF00, 32'hF7F7_FF00, 32'h0, 1'b0, 4'd3}, // R3 all
    '{3'd5, 32'h0084_0000, 64'h0, 32'hF0F7_FF00, 32'h0700_0000, 1'b0, 4'd6},  // R6 f1->c1
    '{3'd5, 32'h0000_0000, 64'h0, 32'h60F7_FF00, 32'hF700_0000, 1'b0, 4'd6},  // R6 f0->c0
    '{3'd5, 32'h0394_0000, 64'h0, 32'h60F7_F800, 32'hF700_000F, 1'b0, 4'd6},  // R6 f5->c7
    '{3'd5, 32'h010C_0000, 64'h0, 32'h60F7_F800, 32'hF770_000F, 1'b0, 4'd6},  // R6 f3->c2
    '{3'd5, 32'h0084_0800, 64'h0, 32'h60F7_F800, 32'hF770_000F, 1'b1, 4'd7},  // R7 rb
    '{3'd5, 32'h00A4_0000, 64'h0, 32'h60F7_F800, 32'hF770_000F, 1'b1, 4'd7},  // R7 dst low
    '{3'd5, 32'h0085_0000, 64'h0, 32'h60F7_F800, 32'hF770_000F, 1'b1, 4'd7},  // R7 src low
    '{3'd1, 32'h0060_0001, 64'h0, 32'h70F7_F800, 32'hF170_000F, 1'b0, 4'd9},  // R9 keep SO
    '{3'd2, 32'h0060_0800, 64'h0, 32'h70F7_F800, 32'hF170_000F, 1'b1, 4'd2},  // R2 reserved
    '{3'd7, 32'h0000_0000, 64'h0, 32'h70F7_F800, 32'hF170_000F, 1'b1, 4'd10}, // R10 code 7
    '{3'd0, 32'h0000_0000, 64'h0, 32'h70F7_F800, 32'hF170_000F, 1'b1, 4'd10}, // R10 code 0
    '{3'd5, 32'h0088_0001, 64'h0, 32'h7007_F800, 32'hFF70_000F, 1'b0, 4'd9},  // R9 copy ignores
    '{3'd4, 32'h0000_0001, 64'h0, 32'h7007_F800, 32'hF170_000F, 1'b0, 4'd9}   // R9 empty mask
  };

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [31:0] ins, input logic [63:0] src);
    @(negedge clk);
    op_valid = 1'b1; op_code = op; instr = ins; fpr_src = src;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "status in reset", {32'h0, status_q}, 64'h0);
    chk("R1", "cr in reset", {32'h0, cr_q}, 64'h0);
    chk("R1", "flags in reset", {61'h0, fpr_we, illegal, |fpr_res}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "status after reset", {32'h0, status_q}, 64'h0);

    for (int k = 0; k < NV; k++) begin
      issue(VECS[k].op, VECS[k].ins, VECS[k].src);
      chk($sformatf("R%0d", VECS[k].req), $sformatf("vec %0d status", k), {32'h0, status_q}, {32'h0, VECS[k].st});
      chk($sformatf("R%0d", VECS[k].req), $sformatf("vec %0d cr", k), {32'h0, cr_q}, {32'h0, VECS[k].cr});
      chk($sformatf("R%0d", VECS[k].req), $sformatf("vec %0d illegal", k), {63'h0, illegal}, {63'h0, VECS[k].ill});
    end

    // R10: illegal pulse lasts one cycle
    @(negedge clk);
    chk("R10", "illegal drops", {63'h0, illegal}, 64'h0);

    // R8: read out
    issue(3'd6, 32'h0000_0000, 64'h0);
    chk("R8", "read value", fpr_res, 64'h0000_0000_7007_F800);
    chk("R8", "read strobe", {63'h0, fpr_we}, 64'h1);
    chk("R8", "read keeps status", {32'h0, status_q}, 64'h7007_F800);
    @(negedge clk);
    chk("R8", "strobe one cycle", {63'h0, fpr_we}, 64'h0);

    // R8: reserved bit makes read illegal
    issue(3'd6, 32'h0000_1000, 64'h0);
    chk("R8", "bad read strobe", {63'h0, fpr_we}, 64'h0);
    chk("R8", "bad read flagged", {63'h0, illegal}, 64'h1);

    // R10: op_valid low ignores the operation
    @(negedge clk);
    op_code = 3'd1; instr = 32'h0080_0000;
    @(negedge clk);
    chk("R10", "idle status", {32'h0, status_q}, 64'h7007_F800);
    chk("R10", "idle flag", {63'h0, illegal}, 64'h0);

    // R3: upper operand half ignored, field 4 only
    issue(3'd4, 32'h0010_0000, 64'hABCD_EF01_0000_5000);
    chk("R3", "single field", {32'h0, status_q}, 64'h7007_5800);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R10 watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule